// File: doc/BRIEF.md
# Key-Protected Boot Control Register

This block is a byte-wide special-function register that governs boot and in-system programming on a small microcontroller bus. It holds three control outputs: an auxiliary-RAM enable, a boot-select flag and a programming-enable flag. It also holds a software-reset bit. A read-only status bit reports which program memory the CPU is currently executing from. Software can change the register only after it opens a guard register. Opening the guard takes two key bytes, written in order to a separate unlock address. Writing zero to that address closes the guard again.

When the software-reset, boot-select and programming-enable bits are all set at the same time, the block issues a one-cycle reset request to the rest of the chip. In the same edge it returns itself to its power-on defaults. Software normally triggers this by writing 0x83 once the guard is open. The bus decode is combinational for reads and registered for writes. Reads have no side effects.

Top module: `boot_ctl_reg`

## Requirements
- R1: After reset the guard is closed, and `aux_ram_en`, `boot_sel`, `prog_en` and `soft_rst_req` are all 0.
- R2: The guard opens once two consecutive writes to the unlock address (parameter, default 0xC7) carry 0x87 and then 0x59. Writes to other addresses in between do not break the sequence. While open, a read of the unlock address returns 0x01.
- R3: The guard stays closed in three cases: 0x59 written without 0x87 just before it; 0x87 followed by any unlock-address write other than 0x59 (0x87 included), which returns the key tracker to idle; and 0x87 followed by 0x59 only after an intervening wrong value.
- R4: Writing 0x00 to the unlock address closes the guard. Afterwards, a read of the unlock address returns 0x00, and writes to the control address no longer change anything.
- R5: A write to the control address (0xBF) while the guard is closed changes no control bit and raises no reset request.
- R6: A write to the control address while the guard is open loads the following bits from the write data: bit 7 (software reset), bit 4 (`aux_ram_en`), bit 1 (`boot_sel`) and bit 0 (`prog_en`). Bits 6, 5, 3 and 2 of the write data are ignored.
- R7: A read of the control address returns the stored bits 7, 4, 1 and 0 in place, with bit 5 equal to the `ldrom_active` input and bits 6, 3 and 2 equal to 0. `sfr_rdata` is 0 when `sfr_rd` is low or when the address is neither of the two registers.
- R8: In the cycle after a write leaves bits 7, 1 and 0 all set, `soft_rst_req` is 1 for exactly one cycle. In that same cycle every control bit is 0 and the guard is closed. No request is raised when only two of the three bits are set.
- R9: A read-modify-write with mask 0xEF clears `aux_ram_en` and leaves bits 7, 1 and 0 unchanged.
- R10: Control-address writes do not change the guard state. The guard stays open until it is closed by a 0x00 write or by a software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | ADDR_W | Bus address |
| sfr_wdata | input | DATA_W | Write data |
| sfr_wr | input | 1 | Write strobe, one cycle per write |
| sfr_rd | input | 1 | Read enable |
| ldrom_active | input | 1 | High while the CPU runs from the loader ROM |
| sfr_rdata | output | DATA_W | Read data, combinational |
| aux_ram_en | output | 1 | Auxiliary RAM enable |
| boot_sel | output | 1 | Boot-select flag |
| prog_en | output | 1 | Programming-enable flag |
| soft_rst_req | output | 1 | One-cycle chip reset request |

## Verification
A key tracker stuck in its half-open state, or one that forgets a wrong byte, shows up on the first read of the unlock address after the bad sequence. It also shows on the next control write, which then either lands or fails to land on the output pins. A reset detector that misses the three-bit combination, or that stretches the request past one cycle, shows within two cycles of the write. The symptoms are the request pin and control outputs that stay set. A read mux that leaks stored reserved bits, or a wrong status bit, is visible on the very same cycle as the read.

// File: rtl/boot_ctl_pkg.sv
package boot_ctl_pkg;

    localparam int BIT_SWRST   = 7;
    localparam int BIT_MEMSEL  = 5;
    localparam int BIT_AUXRAM  = 4;
    localparam int BIT_BOOTSEL = 1;
    localparam int BIT_PROGEN  = 0;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    typedef struct packed {
        logic swrst;
        logic aux;
        logic boot;
        logic prog;
    } ctrl_bits_t;

endpackage

// File: rtl/boot_ctl_key.sv
module boot_ctl_key
    import boot_ctl_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h87,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59,
    parameter logic [DATA_W-1:0] LOCK_CODE  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              soft_clr,
    output logic              unlocked
);

    typedef struct packed {
        key_state_e st;
    } key_regs_t;

    key_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (soft_clr) begin
            r_d.st = KEY_IDLE;
        end else if (key_wr) begin
            if (key_data == LOCK_CODE) begin
                r_d.st = KEY_IDLE;
            end else begin
                unique case (r_q.st)
                    KEY_IDLE: r_d.st = (key_data == KEY_FIRST)  ? KEY_HALF : KEY_IDLE;
                    KEY_HALF: r_d.st = (key_data == KEY_SECOND) ? KEY_OPEN : KEY_IDLE;
                    KEY_OPEN: r_d.st = KEY_OPEN;
                    default:  r_d.st = KEY_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: KEY_IDLE};
        else        r_q <= r_d;
    end

    assign unlocked = (r_q.st == KEY_OPEN);

endmodule

// File: rtl/boot_ctl_bits.sv
module boot_ctl_bits
    import boot_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  ctrl_bits_t wr_val,
    input  logic       unlocked,
    output ctrl_bits_t bits,
    output logic       soft_clr,
    output logic       soft_rst_req
);

    typedef struct packed {
        ctrl_bits_t bits;
        logic       req;
    } bits_regs_t;

    bits_regs_t r_d, r_q;
    logic       trig;

    assign trig = r_q.bits.swrst & r_q.bits.boot & r_q.bits.prog;

    always_comb begin
        r_d     = r_q;
        r_d.req = trig;
        if (trig) begin
            r_d.bits = '0;
        end else if (ctrl_wr && unlocked) begin
            r_d.bits = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bits         = r_q.bits;
    assign soft_clr     = trig;
    assign soft_rst_req = r_q.req;

endmodule

// File: rtl/boot_ctl_rdmux.sv
module boot_ctl_rdmux
    import boot_ctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hBF,
    parameter logic [ADDR_W-1:0] UNLK_ADDR = 8'hC7
) (
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_bits_t        bits,
    input  logic              unlocked,
    input  logic              ldrom_active,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] ctrl_view;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            unique case (i)
                BIT_SWRST:   ctrl_view[i] = bits.swrst;
                BIT_MEMSEL:  ctrl_view[i] = ldrom_active;
                BIT_AUXRAM:  ctrl_view[i] = bits.aux;
                BIT_BOOTSEL: ctrl_view[i] = bits.boot;
                BIT_PROGEN:  ctrl_view[i] = bits.prog;
                default:     ctrl_view[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == CTRL_ADDR)      rdata = ctrl_view;
            else if (addr == UNLK_ADDR) rdata = {{(DATA_W-1){1'b0}}, unlocked};
        end
    end

endmodule

// File: rtl/boot_ctl_reg.sv
module boot_ctl_reg
    import boot_ctl_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hBF,
    parameter logic [ADDR_W-1:0] UNLK_ADDR  = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h87,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59,
    parameter logic [DATA_W-1:0] LOCK_CODE  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              sfr_wr,
    input  logic              sfr_rd,
    input  logic              ldrom_active,
    output logic [DATA_W-1:0] sfr_rdata,
    output logic              aux_ram_en,
    output logic              boot_sel,
    output logic              prog_en,
    output logic              soft_rst_req
);

    logic       key_wr;
    logic       ctrl_wr;
    logic       unlocked;
    logic       soft_clr;
    ctrl_bits_t wr_val;
    ctrl_bits_t bits;

    assign key_wr  = sfr_wr && (sfr_addr == UNLK_ADDR);
    assign ctrl_wr = sfr_wr && (sfr_addr == CTRL_ADDR);

    assign wr_val = '{swrst: sfr_wdata[BIT_SWRST],
                      aux:   sfr_wdata[BIT_AUXRAM],
                      boot:  sfr_wdata[BIT_BOOTSEL],
                      prog:  sfr_wdata[BIT_PROGEN]};

    boot_ctl_key #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND),
        .LOCK_CODE (LOCK_CODE)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_data(sfr_wdata),
        .soft_clr(soft_clr),
        .unlocked(unlocked)
    );

    boot_ctl_bits u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wr_val      (wr_val),
        .unlocked    (unlocked),
        .bits        (bits),
        .soft_clr    (soft_clr),
        .soft_rst_req(soft_rst_req)
    );

    boot_ctl_rdmux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_ADDR(CTRL_ADDR),
        .UNLK_ADDR(UNLK_ADDR)
    ) u_rdmux (
        .rd          (sfr_rd),
        .addr        (sfr_addr),
        .bits        (bits),
        .unlocked    (unlocked),
        .ldrom_active(ldrom_active),
        .rdata       (sfr_rdata)
    );

    assign aux_ram_en = bits.aux;
    assign boot_sel   = bits.boot;
    assign prog_en    = bits.prog;

endmodule

// File: rtl/boot_ctl_reg_chk.sv
module boot_ctl_reg_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hBF,
    parameter logic [ADDR_W-1:0] UNLK_ADDR  = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59,
    parameter logic [DATA_W-1:0] LOCK_CODE  = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic              sfr_wr,
    input logic              sfr_rd,
    input logic              ldrom_active,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic              aux_ram_en,
    input logic              boot_sel,
    input logic              prog_en,
    input logic              soft_rst_req,
    input logic              unlocked
);

    p_req_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |=> !soft_rst_req);

    p_req_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> (!aux_ram_en && !boot_sel && !prog_en && !unlocked));

    p_locked_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == CTRL_ADDR && !unlocked)
        |=> ($stable({aux_ram_en, boot_sel, prog_en}) || soft_rst_req));

    p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(sfr_wr && sfr_addr == UNLK_ADDR && sfr_wdata == KEY_SECOND));

    p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == UNLK_ADDR && sfr_wdata == LOCK_CODE) |=> !unlocked);

    p_ctrl_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && sfr_addr == CTRL_ADDR)
        |-> (sfr_rdata[5] == ldrom_active && sfr_rdata[6] == 1'b0 && sfr_rdata[3:2] == 2'b00));

    p_unlk_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && sfr_addr == UNLK_ADDR) |-> (sfr_rdata == {{(DATA_W-1){1'b0}}, unlocked}));

    p_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_rd |-> (sfr_rdata == '0));

endmodule

bind boot_ctl_reg boot_ctl_reg_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .UNLK_ADDR (UNLK_ADDR),
    .KEY_SECOND(KEY_SECOND),
    .LOCK_CODE (LOCK_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfr_addr    (sfr_addr),
    .sfr_wdata   (sfr_wdata),
    .sfr_wr      (sfr_wr),
    .sfr_rd      (sfr_rd),
    .ldrom_active(ldrom_active),
    .sfr_rdata   (sfr_rdata),
    .aux_ram_en  (aux_ram_en),
    .boot_sel    (boot_sel),
    .prog_en     (prog_en),
    .soft_rst_req(soft_rst_req),
    .unlocked    (unlocked)
);

// File: tb/boot_ctl_reg_bench.sv
`timescale 1ns/1ps
module boot_ctl_reg_bench;

    localparam logic [7:0] CTRL_A = 8'hBF;
    localparam logic [7:0] UNLK_A = 8'hC7;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic       sfr_wr;
    logic       sfr_rd;
    logic       ldrom_active;
    logic [7:0] sfr_rdata;
    logic       aux_ram_en;
    logic       boot_sel;
    logic       prog_en;
    logic       soft_rst_req;

    always #2.5 clk = ~clk;

    boot_ctl_reg u_boot_ctl_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sfr_addr    (sfr_addr),
        .sfr_wdata   (sfr_wdata),
        .sfr_wr      (sfr_wr),
        .sfr_rd      (sfr_rd),
        .ldrom_active(ldrom_active),
        .sfr_rdata   (sfr_rdata),
        .aux_ram_en  (aux_ram_en),
        .boot_sel    (boot_sel),
        .prog_en     (prog_en),
        .soft_rst_req(soft_rst_req)
    );

    typedef struct {
        logic [7:0] rdata;
        logic [3:0] pins;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // monitor: compares the outputs just after each falling edge
    always @(negedge clk) begin
        exp_t e;
        logic [3:0] act_pins;
        #1;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            act_pins = {soft_rst_req, aux_ram_en, boot_sel, prog_en};
            checks++;
            if (sfr_rdata !== e.rdata || act_pins !== e.pins) begin
                errors++;
                $display("FAIL %s: actual rdata=%h pins=%b expected rdata=%h pins=%b",
                         e.tag, sfr_rdata, act_pins, e.rdata, e.pins);
            end
        end
    end

    task automatic drive(input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr    = wr;
        sfr_rd    = rd;
        sfr_addr  = a;
        sfr_wdata = d;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        drive(1'b1, 1'b0, a, d);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] rd_exp,
                             input logic [3:0] pins_exp, input string tag);
        exp_t e;
        drive(1'b0, 1'b1, a, 8'h00);
        e.rdata = rd_exp; e.pins = pins_exp; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic expect_pins(input logic [3:0] pins_exp, input string tag);
        exp_t e;
        drive(1'b0, 1'b0, 8'h00, 8'h00);
        e.rdata = 8'h00; e.pins = pins_exp; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sfr_wr = 1'b0; sfr_rd = 1'b0;
        sfr_addr = 8'h00; sfr_wdata = 8'h00; ldrom_active = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(CTRL_A, 8'h00, 4'b0000, "R1 ctrl after reset");
        expect_rd(UNLK_A, 8'h00, 4'b0000, "R1 guard closed after reset");

        // R7 status bit follows input
        ldrom_active = 1'b1;
        expect_rd(CTRL_A, 8'h20, 4'b0000, "R7 status bit");
        expect_rd(8'h55, 8'h00, 4'b0000, "R7 other address reads 0");
        expect_pins(4'b0000, "R7 idle read is 0");

        // R5 locked write discarded
        wr_reg(CTRL_A, 8'hFF);
        expect_rd(CTRL_A, 8'h20, 4'b0000, "R5 locked write");

        // R3 bad sequences
        wr_reg(UNLK_A, 8'h59);
        expect_rd(UNLK_A, 8'h00, 4'b0000, "R3 lone second key");
        wr_reg(UNLK_A, 8'h87); wr_reg(UNLK_A, 8'h12); wr_reg(UNLK_A, 8'h59);
        expect_rd(UNLK_A, 8'h00, 4'b0000, "R3 wrong byte between keys");
        wr_reg(UNLK_A, 8'h87); wr_reg(UNLK_A, 8'h87); wr_reg(UNLK_A, 8'h59);
        expect_rd(UNLK_A, 8'h00, 4'b0000, "R3 repeated first key");

        // R2 unlock, other-address write in between
        wr_reg(UNLK_A, 8'h87); wr_reg(CTRL_A, 8'hFF); wr_reg(UNLK_A, 8'h59);
        expect_rd(UNLK_A, 8'h01, 4'b0000, "R2 guard open");
        expect_rd(CTRL_A, 8'h20, 4'b0000, "R5 write before open discarded");

        // R6 writable bits only
        wr_reg(CTRL_A, 8'h7E);
        expect_rd(CTRL_A, 8'h32, 4'b0110, "R6 masked write");

        // R9 read-modify-write with 0xEF
        wr_reg(CTRL_A, 8'h32 & 8'hEF);
        expect_rd(CTRL_A, 8'h22, 4'b0010, "R9 aux cleared only");
        wr_reg(CTRL_A, 8'h13);
        expect_rd(CTRL_A, 8'h33, 4'b0111, "R6 aux boot prog set");

        // R8 two of three bits: no request
        wr_reg(CTRL_A, 8'h82);
        expect_rd(CTRL_A, 8'hA2, 4'b0010, "R8 two bits no request");
        expect_pins(4'b0010, "R8 still no request");

        // R10 guard unaffected by control writes
        expect_rd(UNLK_A, 8'h01, 4'b0010, "R10 guard stays open");

        // R4 relock
        wr_reg(UNLK_A, 8'h00);
        expect_rd(UNLK_A, 8'h00, 4'b0010, "R4 guard closed");
        wr_reg(CTRL_A, 8'h11);
        expect_rd(CTRL_A, 8'hA2, 4'b0010, "R4 write after relock discarded");

        // R8 software reset
        wr_reg(UNLK_A, 8'h87); wr_reg(UNLK_A, 8'h59);
        wr_reg(CTRL_A, 8'h83);
        expect_rd(CTRL_A, 8'hA3, 4'b0011, "R8 reset bits stored");
        expect_rd(CTRL_A, 8'h20, 4'b1000, "R8 request pulse and clear");
        expect_rd(UNLK_A, 8'h00, 4'b0000, "R8 pulse over, guard closed");

        // R5 reset value while locked does nothing
        wr_reg(CTRL_A, 8'h83);
        expect_pins(4'b0000, "R5 locked reset write");
        expect_pins(4'b0000, "R5 no request");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule